// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the fetch address for an 11-bit instruction space of 2K words. The space is split into two pages of 1024 words: page 0 spans 0x000 to 0x3FF and page 1 spans 0x400 to 0x7FF. Each cycle the sequencer gives the block one command: step, jump, call, return, return-from-interrupt, load or hold. The block then moves the counter. Jumps and calls take the low ten address bits from the instruction target. The page bit comes from a separate page-select register value. The page-select register itself lives outside the block.

An eight-entry circular stack of 12-bit words holds return addresses. A call or an accepted interrupt pushes the address after the current one. Both return commands pop it. Return-from-interrupt also gives a one-cycle pulse that re-enables interrupts globally. An accepted interrupt has priority over the command in the same cycle and sends the counter to a fixed vector. A load writes the whole 11-bit address from the target bus, so data-bus writes to the counter can reach it.

Top module: `pc_page_stack`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0x000, `depth_o` is 0 and `gie_set_o` is 0. Execution therefore starts at address 0x000 after reset.
- R2: With `cmd_i` = 0 (step) and no interrupt, `pc_o` advances by one on the next clock edge. The step wraps within 11 bits, so 0x7FF goes to 0x000, and bit 11 of `pc_o` stays 0.
- R3: With `cmd_i` = 1 (jump), the new `pc_o` takes bits 9:0 from `tgt_i[9:0]` and bit 10 from `page_i`. `tgt_i[10]` has no effect on a jump.
- R4: With `cmd_i` = 2 (call), the counter is formed as in R3. The call also pushes the old `pc_o` + 1 (wrapped as in R2) and raises `depth_o` by one.
- R5: With `cmd_i` = 3 (return) or 4 (return-from-interrupt), `pc_o` becomes the most recently pushed address and `depth_o` falls by one. Return addresses come back in last-in, first-out order.
- R6: `gie_set_o` is high for exactly the one cycle after an accepted return-from-interrupt command. It is low after every other command.
- R7: When `irq_take_i` is high, `cmd_i` is ignored. The old `pc_o` + 1 is pushed, and `pc_o` becomes the interrupt vector (default 0x003).
- R8: With `cmd_i` = 5 (load), `pc_o` becomes `tgt_i[10:0]` in full. `page_i` has no effect on a load.
- R9: With `cmd_i` = 6 or 7 (hold), `pc_o` and `depth_o` do not change.
- R10: The stack has eight slots and its pointer wraps. A ninth push overwrites the oldest entry, and `depth_o` stays at 8.
- R11: A pop at depth 0 leaves `depth_o` at 0, and the pointer still wraps. After nine pushes of v0 to v8, eight pops return v8 down to v1, and a ninth pop returns v8 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 step, 1 jump, 2 call, 3 return, 4 return-from-interrupt, 5 load, 6/7 hold |
| irq_take_i | input | 1 | Interrupt accepted this cycle; overrides `cmd_i` |
| tgt_i | input | 11 | Target address: bits 9:0 for jump and call, all bits for load |
| page_i | input | 1 | Page-select register value, used as bit 10 on jump and call |
| pc_o | output | 12 | Current fetch address |
| depth_o | output | 4 | Number of valid stack entries, 0 to 8 |
| gie_set_o | output | 1 | One-cycle pulse that re-enables interrupts globally |

## Verification
The assertions assume that `cmd_i`, `irq_take_i`, `tgt_i` and `page_i` hold known values at each rising edge. They also assume that the interrupt strobe is the only source of priority, so any command that is paired with an accepted interrupt is dropped. The bench keeps to this by changing inputs only two nanoseconds after an edge and never leaving an input undriven. It combines interrupts only with commands whose loss it expects. In the depth assertion, the stack-occupancy check applies only to calls made while the depth is below eight. The bench drives both the overflow and underflow cases on purpose, to exercise the saturation and wrap rules.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [2:0] {
      PC_STEP  = 3'd0,
      PC_JUMP  = 3'd1,
      PC_CALL  = 3'd2,
      PC_RET   = 3'd3,
      PC_RETI  = 3'd4,
      PC_LOAD  = 3'd5,
      PC_HOLD  = 3'd6,
      PC_HOLD2 = 3'd7
   } pc_cmd_e;

endpackage

// File: rtl/pcs_next.sv
module pcs_next
   import pcs_pkg::*;
#(
   parameter int unsigned PC_W    = 12,
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned PAGE_W  = 10,
   parameter int unsigned IRQ_VEC = 3,
   localparam int unsigned SEL_W  = ADDR_W - PAGE_W
) (
   input  logic [PC_W-1:0]   pc_i,
   input  logic [2:0]        cmd_i,
   input  logic              irq_i,
   input  logic [ADDR_W-1:0] tgt_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [PC_W-1:0]   top_i,
   output logic [PC_W-1:0]   nxt_o,
   output logic              push_o,
   output logic              pop_o,
   output logic [PC_W-1:0]   push_val_o,
   output logic              reti_o
);

   logic [ADDR_W-1:0] inc_a, jmp_a;
   logic [PC_W-1:0]   inc_w, jmp_w, ld_w;
   pc_cmd_e           cmd;

   assign cmd   = pc_cmd_e'(cmd_i);
   assign inc_a = pc_i[ADDR_W-1:0] + ADDR_W'(1);
   assign jmp_a = {sel_i, tgt_i[PAGE_W-1:0]};

   generate
      if (PC_W > ADDR_W) begin : g_pad
         localparam int unsigned PAD = PC_W - ADDR_W;
         assign inc_w = {{PAD{1'b0}}, inc_a};
         assign jmp_w = {{PAD{1'b0}}, jmp_a};
         assign ld_w  = {{PAD{1'b0}}, tgt_i};
      end else begin : g_flat
         assign inc_w = inc_a;
         assign jmp_w = jmp_a;
         assign ld_w  = tgt_i;
      end
   endgenerate

   assign push_val_o = inc_w;

   always_comb begin
      nxt_o  = pc_i;
      push_o = 1'b0;
      pop_o  = 1'b0;
      reti_o = 1'b0;
      if (irq_i) begin
         nxt_o  = PC_W'(IRQ_VEC);
         push_o = 1'b1;
      end else begin
         unique case (cmd)
            PC_STEP: nxt_o = inc_w;
            PC_JUMP: nxt_o = jmp_w;
            PC_CALL: begin
               nxt_o  = jmp_w;
               push_o = 1'b1;
            end
            PC_RET: begin
               nxt_o = top_i;
               pop_o = 1'b1;
            end
            PC_RETI: begin
               nxt_o  = top_i;
               pop_o  = 1'b1;
               reti_o = 1'b1;
            end
            PC_LOAD: nxt_o = ld_w;
            PC_HOLD, PC_HOLD2: nxt_o = pc_i;
            default: nxt_o = pc_i;
         endcase
      end
   end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
   parameter int unsigned W      = 12,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [W-1:0]     val_i,
   output logic [W-1:0]     top_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [W-1:0]     slot_q [DEPTH];
   logic [PTR_W-1:0] sp_q, sp_dn;
   logic [CNT_W-1:0] cnt_q;

   assign sp_dn = sp_q - PTR_W'(1);
   assign top_o = slot_q[sp_dn];
   assign cnt_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (push_i) begin
         slot_q[sp_q] <= val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= '0;
         cnt_q <= '0;
      end else if (push_i) begin
         sp_q <= sp_q + PTR_W'(1);
         if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop_i) begin
         sp_q <= sp_dn;
         if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/pc_page_stack.sv
module pc_page_stack #(
   parameter int unsigned PC_W    = 12,
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned PAGE_W  = 10,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned IRQ_VEC = 3,
   localparam int unsigned SEL_W  = ADDR_W - PAGE_W,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_i,
   input  logic              irq_take_i,
   input  logic [ADDR_W-1:0] tgt_i,
   input  logic [SEL_W-1:0]  page_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [CNT_W-1:0]  depth_o,
   output logic              gie_set_o
);

   generate
      if (ADDR_W > PC_W) begin : g_bad_addr
         $error("ADDR_W must not exceed PC_W");
      end
      if (PAGE_W >= ADDR_W) begin : g_bad_page
         $error("PAGE_W must be below ADDR_W");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (IRQ_VEC >= (1 << ADDR_W)) begin : g_bad_vec
         $error("IRQ_VEC outside the address space");
      end
   endgenerate

   logic [PC_W-1:0] pc_q, nxt, top, push_val;
   logic            push, pop, reti, gie_q;

   pcs_next #(
      .PC_W(PC_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IRQ_VEC(IRQ_VEC)
   ) u_next (
      .pc_i(pc_q), .cmd_i(cmd_i), .irq_i(irq_take_i), .tgt_i(tgt_i),
      .sel_i(page_i), .top_i(top), .nxt_o(nxt), .push_o(push),
      .pop_o(pop), .push_val_o(push_val), .reti_o(reti)
   );

   pcs_stack #(
      .W(PC_W), .DEPTH(DEPTH)
   ) u_stack (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
      .val_i(push_val), .top_o(top), .cnt_o(depth_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         gie_q <= 1'b0;
      end else begin
         pc_q  <= nxt;
         gie_q <= reti;
      end
   end

   assign pc_o      = pc_q;
   assign gie_set_o = gie_q;

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
   parameter int unsigned PC_W    = 12,
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned PAGE_W  = 10,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned IRQ_VEC = 3,
   localparam int unsigned SEL_W  = ADDR_W - PAGE_W,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cmd_i,
   input logic              irq_take_i,
   input logic [ADDR_W-1:0] tgt_i,
   input logic [SEL_W-1:0]  page_i,
   input logic [PC_W-1:0]   pc_o,
   input logic [CNT_W-1:0]  depth_o,
   input logic              gie_set_o
);

   // R2
   step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd0 && !irq_take_i) |=>
      pc_o[ADDR_W-1:0] == ADDR_W'($past(pc_o[ADDR_W-1:0]) + ADDR_W'(1)));

   // R3
   jump_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd1 && !irq_take_i) |=>
      pc_o[ADDR_W-1:0] == {$past(page_i), $past(tgt_i[PAGE_W-1:0])});

   // R4
   call_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd2 && !irq_take_i && depth_o < CNT_W'(DEPTH)) |=>
      depth_o == CNT_W'($past(depth_o) + CNT_W'(1)));

   // R6
   gie_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd4 && !irq_take_i) |=> gie_set_o);

   // R6
   gie_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_i == 3'd4 && !irq_take_i) |=> !gie_set_o);

   // R7
   irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_i |=> pc_o == PC_W'(IRQ_VEC));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i[2:1] == 2'b11 && !irq_take_i) |=> ($stable(pc_o) && $stable(depth_o)));

   // R10
   depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth_o <= CNT_W'(DEPTH));

endmodule

bind pc_page_stack pcs_chk #(
   .PC_W(PC_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH), .IRQ_VEC(IRQ_VEC)
) u_chk (.*);

// File: tb/sim_pc_page_stack.sv
module sim_pc_page_stack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd6;
   logic        irq = 1'b0;
   logic [10:0] tgt = '0;
   logic        page = 1'b0;
   logic [11:0] pc;
   logic [3:0]  depth;
   logic        gie;
   int          checks = 0;
   int          errors = 0;

   always #4 clk = ~clk;

   pc_page_stack u0 (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .irq_take_i(irq), .tgt_i(tgt),
      .page_i(page), .pc_o(pc), .depth_o(depth), .gie_set_o(gie)
   );

   // {cmd, irq, page, tgt, expected pc, expected depth}
   localparam int NV = 15;
   localparam logic [31:0] VEC [NV] = '{
      {3'd0, 1'b0, 1'b0, 11'h000, 12'h001, 4'd0},
      {3'd0, 1'b0, 1'b0, 11'h000, 12'h002, 4'd0},
      {3'd1, 1'b0, 1'b0, 11'h155, 12'h155, 4'd0},
      {3'd2, 1'b0, 1'b1, 11'h020, 12'h420, 4'd1},
      {3'd0, 1'b0, 1'b0, 11'h000, 12'h421, 4'd1},
      {3'd1, 1'b0, 1'b1, 11'h3FF, 12'h7FF, 4'd1},
      {3'd0, 1'b0, 1'b0, 11'h000, 12'h000, 4'd1},
      {3'd5, 1'b0, 1'b0, 11'h7FE, 12'h7FE, 4'd1},
      {3'd2, 1'b0, 1'b0, 11'h010, 12'h010, 4'd2},
      {3'd1, 1'b1, 1'b1, 11'h2AA, 12'h003, 4'd3},
      {3'd6, 1'b0, 1'b1, 11'h2AA, 12'h003, 4'd3},
      {3'd4, 1'b0, 1'b0, 11'h000, 12'h011, 4'd2},
      {3'd3, 1'b0, 1'b0, 11'h000, 12'h7FF, 4'd1},
      {3'd3, 1'b0, 1'b0, 11'h000, 12'h156, 4'd0},
      {3'd1, 1'b0, 1'b0, 11'h7AB, 12'h3AB, 4'd0}
   };

   function automatic string tag_of(logic [2:0] c, logic i);
      if (i) return "R7";
      case (c)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3, 3'd4: return "R5";
         3'd5: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(string req, logic [11:0] got, logic [11:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(logic [2:0] c, logic i, logic p, logic [10:0] t);
      cmd = c; irq = i; page = p; tgt = t;
      @(posedge clk);
      #2;
   endtask

   initial begin : watchdog
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check("R1", pc, 12'h000);
      check("R1", {8'h0, depth}, 12'd0);
      check("R1", {11'h0, gie}, 12'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         drive(VEC[k][31:29], VEC[k][28], VEC[k][27], VEC[k][26:16]);
         check(tag_of(VEC[k][31:29], VEC[k][28]), pc, VEC[k][15:4]);
         check(tag_of(VEC[k][31:29], VEC[k][28]), {8'h0, depth}, {8'h0, VEC[k][3:0]});
      end

      // R6 pulse after return-from-interrupt only
      drive(3'd2, 1'b0, 1'b0, 11'h050);
      check("R6", {11'h0, gie}, 12'd0);
      drive(3'd4, 1'b0, 1'b0, 11'h000);
      check("R6", {11'h0, gie}, 12'd1);
      check("R5", pc, 12'h3AC);
      drive(3'd0, 1'b0, 1'b0, 11'h000);
      check("R6", {11'h0, gie}, 12'd0);
      drive(3'd3, 1'b0, 1'b0, 11'h000);
      check("R6", {11'h0, gie}, 12'd0);

      // R9 code 7 holds
      drive(3'd5, 1'b0, 1'b1, 11'h1C0);
      check("R8", pc, 12'h1C0);
      drive(3'd7, 1'b0, 1'b0, 11'h7FF);
      check("R9", pc, 12'h1C0);

      // R10 overflow after fresh reset
      rst_n = 1'b0;
      #2;
      check("R1", pc, 12'h000);
      check("R1", {8'h0, depth}, 12'd0);
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      for (int k = 0; k < 9; k++) begin
         drive(3'd5, 1'b0, 1'b0, 11'(12'h200 + k));
         drive(3'd2, 1'b0, 1'b0, 11'h000);
      end
      check("R10", {8'h0, depth}, 12'd8);
      for (int k = 8; k >= 1; k--) begin
         drive(3'd3, 1'b0, 1'b0, 11'h000);
         check("R10", pc, 12'(12'h201 + k));
      end
      check("R11", {8'h0, depth}, 12'd0);
      // R11 pop at depth 0
      drive(3'd3, 1'b0, 1'b0, 11'h000);
      check("R11", pc, 12'h209);
      check("R11", {8'h0, depth}, 12'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule